// File: doc/BRIEF.md
# Tapered-Width MASH 1-2 Sigma-Delta Modulator

This block produces the modulus-offset sequence for a fractional-N feedback divider. A fractional word sets the wanted fraction of the reference frequency. Each enabled clock, the block emits a small signed offset that the divider adds to its integer ratio. The long-run average of that offset equals the fraction, and the quantization error is pushed toward high frequencies, where the loop filter removes it.

The modulator has two sections. The first is a first-order section with a wide accumulator. The second is a second-order section built from two narrower accumulators. Each later accumulator receives only the upper bits of the residue held by the one before it, so the register width shrinks from stage to stage. The two quantizer outputs are aligned in time and combined through difference terms into one four-bit output.

An enable input freezes the modulator and forces its output to zero. An active-low clear returns the whole datapath to zero.

Top module: `mash12_mod`

## Requirements
- R1: With `frac_i` = F held and `en_i` high, over 4096 consecutive enabled cycles after a clear, the sum of `y_o` is within ±4 of floor(4096·F / 2^21). The represented fraction is F / 2^21.
- R2: The first accumulator is 24 bits wide. On each enabled edge it adds `frac_i`·8. The carry out of bit 24 is registered as q1.
- R3: The second accumulator is 12 bits wide. On each enabled edge it adds bits [23:12] of the first accumulator, taking the value held before that edge. Its carry out is registered as c2.
- R4: The third accumulator is 10 bits wide. On each enabled edge it adds bits [11:2] of the second accumulator, taking the value held before that edge. Its carry out is registered as c3.
- R5: The second-section quantizer value is q2 = c2(previous enabled edge) + c3 − c3(previous enabled edge). It is always within −1..2.
- R6: On each enabled edge, `y_o` is registered as q1 (taken two enabled edges back) + q2 − q2(previous enabled edge). The output is 4-bit two's complement and always within −3..4.
- R7: An edge with `en_i` low and `clr_ni` high sets `y_o` to 0 and holds every accumulator and delay register. When the enable returns, the sequence continues exactly where it stopped.
- R8: An edge with `clr_ni` low sets all accumulators, carries, delay registers and `y_o` to 0. The clear takes priority over `en_i`.
- R9: `rst_ni` low asynchronously sets all state and `y_o` to 0.
- R10: With `frac_i` = 0 from a clear, `y_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Modulator enable |
| clr_ni | input | 1 | Synchronous clear, active low |
| frac_i | input | 21 | Unsigned fractional word |
| y_o | output | 4 | Signed divider offset |

## Verification
The bench builds the block with its default widths: a 21-bit input, and accumulators of 24, 12 and 10 bits. The 10-bit third stage wraps within a few hundred cycles. This lets random runs of a few hundred cycles exercise carries in all three stages, along with the full −3..4 output swing. Windows of 4096 cycles resolve the output mean to 1/512 of a unit. This makes the average-versus-fraction check sharp at both extremes of the input word. An independent cycle model built from the stated equations is compared against the output every cycle, under random enable and clear patterns.

// File: rtl/mash12_pkg.sv
package mash12_pkg;
  localparam int unsigned Q_W   = 3;
  localparam int unsigned OUT_W = 4;
  typedef logic signed [Q_W-1:0]   q_t;
  typedef logic signed [OUT_W-1:0] y_t;
endpackage

// File: rtl/mash12_acc.sv
module mash12_acc #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_ni,
  input  logic         en_i,
  input  logic [W-1:0] add_i,
  output logic [W-1:0] acc_o,
  output logic         cy_o
);
  logic [W-1:0] acc_q;
  logic         cy_q;
  logic [W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, add_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (!clr_ni) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (en_i) begin
      {cy_q, acc_q} <= sum;
    end
  end

  assign acc_o = acc_q;
  assign cy_o  = cy_q;

  // R8
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (acc_o == '0) && !cy_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !en_i) |=> ($stable(acc_o) && $stable(cy_o)));
endmodule

// File: rtl/mash12_comb.sv
module mash12_comb
  import mash12_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  input  logic en_i,
  input  logic c1_i,
  input  logic c2_i,
  input  logic c3_i,
  output y_t   y_o
);
  logic c1_d1, c1_d2, c2_d, c3_d;
  q_t   q2, q2_d;
  y_t   y_nxt, y_q;

  always_comb begin
    q2    = q_t'({{(Q_W-1){1'b0}}, c2_d}) + q_t'({{(Q_W-1){1'b0}}, c3_i})
          - q_t'({{(Q_W-1){1'b0}}, c3_d});
    y_nxt = y_t'({{(OUT_W-1){1'b0}}, c1_d2}) + y_t'(q2) - y_t'(q2_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {c1_d1, c1_d2, c2_d, c3_d} <= '0;
      q2_d <= '0;
      y_q  <= '0;
    end else if (!clr_ni) begin
      {c1_d1, c1_d2, c2_d, c3_d} <= '0;
      q2_d <= '0;
      y_q  <= '0;
    end else if (en_i) begin
      c1_d1 <= c1_i;
      c1_d2 <= c1_d1;
      c2_d  <= c2_i;
      c3_d  <= c3_i;
      q2_d  <= q2;
      y_q   <= y_nxt;
    end else begin
      y_q <= '0;
    end
  end

  assign y_o = y_q;

  // R5
  q2_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q2 >= -1) && (q2 <= 2));

  // R6
  y_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_o >= -3) && (y_o <= 4));

  // R7
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !en_i) |=> (y_o == '0));
endmodule

// File: rtl/mash12_mod.sv
module mash12_mod
  import mash12_pkg::*;
#(
  parameter int unsigned IN_W   = 21,
  parameter int unsigned ACC1_W = 24,
  parameter int unsigned ACC2_W = 12,
  parameter int unsigned ACC3_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clr_ni,
  input  logic [IN_W-1:0] frac_i,
  output logic [OUT_W-1:0] y_o
);
  localparam int unsigned SHIFT = ACC1_W - IN_W;

  logic [ACC1_W-1:0] acc1, add1;
  logic [ACC2_W-1:0] acc2, add2;
  logic [ACC3_W-1:0] acc3, add3;
  logic              c1, c2, c3;
  y_t                y;

  assign add1 = {frac_i, {SHIFT{1'b0}}};

  // truncated residue hand-off; pad when a later stage is not narrower
  if (ACC2_W <= ACC1_W) begin : g_trunc2
    assign add2 = acc1[ACC1_W-1 -: ACC2_W];
  end else begin : g_pad2
    assign add2 = {acc1, {(ACC2_W-ACC1_W){1'b0}}};
  end

  if (ACC3_W <= ACC2_W) begin : g_trunc3
    assign add3 = acc2[ACC2_W-1 -: ACC3_W];
  end else begin : g_pad3
    assign add3 = {acc2, {(ACC3_W-ACC2_W){1'b0}}};
  end

  mash12_acc #(.W(ACC1_W)) u_acc1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .en_i(en_i),
    .add_i(add1), .acc_o(acc1), .cy_o(c1));

  mash12_acc #(.W(ACC2_W)) u_acc2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .en_i(en_i),
    .add_i(add2), .acc_o(acc2), .cy_o(c2));

  mash12_acc #(.W(ACC3_W)) u_acc3 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .en_i(en_i),
    .add_i(add3), .acc_o(acc3), .cy_o(c3));

  mash12_comb u_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .en_i(en_i),
    .c1_i(c1), .c2_i(c2), .c3_i(c3), .y_o(y));

  assign y_o = y;

  // R10
  zero_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frac_i == '0 && acc1 == '0 && acc2 == '0 && acc3 == '0 && !c1 && !c2 && !c3)
      |=> (acc1 == '0));
endmodule

// File: tb/mash12_mod_tb_top.sv
module mash12_mod_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        clr_ni = 1'b1;
  logic [20:0] frac_i = '0;
  logic [3:0]  y_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk_i = ~clk_i;

  mash12_mod dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .clr_ni(clr_ni),
    .frac_i(frac_i), .y_o(y_o));

  // independent model built from R2..R8
  logic [23:0] m_a1;
  logic [11:0] m_a2;
  logic [9:0]  m_a3;
  bit m_c1, m_c2, m_c3, m_c1d1, m_c1d2, m_c2d, m_c3d;
  int m_q2d, m_y;

  task automatic m_zero();
    m_a1 = '0; m_a2 = '0; m_a3 = '0;
    {m_c1, m_c2, m_c3, m_c1d1, m_c1d2, m_c2d, m_c3d} = '0;
    m_q2d = 0; m_y = 0;
  endtask

  task automatic m_step();
    logic [24:0] s1;
    logic [12:0] s2;
    logic [10:0] s3;
    int q2;
    if (!clr_ni) m_zero();
    else if (en_i) begin
      q2  = int'(m_c2d) + int'(m_c3) - int'(m_c3d);
      m_y = int'(m_c1d2) + q2 - m_q2d;
      m_c1d2 = m_c1d1; m_c1d1 = m_c1; m_c2d = m_c2; m_c3d = m_c3; m_q2d = q2;
      s1 = {1'b0, m_a1} + {1'b0, frac_i, 3'b000};
      s2 = {1'b0, m_a2} + {1'b0, m_a1[23:12]};
      s3 = {1'b0, m_a3} + {1'b0, m_a2[11:2]};
      {m_c1, m_a1} = s1;
      {m_c2, m_a2} = s2;
      {m_c3, m_a3} = s3;
    end else m_y = 0;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk_i);
    m_step();
    @(negedge clk_i);
    chk(tag, int'($signed(y_o)), m_y);
  endtask

  task automatic run(string tag, int n, int en_pct, int clr_pct);
    for (int i = 0; i < n; i++) begin
      en_i   = (($urandom % 100) < en_pct);
      clr_ni = !(($urandom % 1000) < clr_pct);
      tick(!clr_ni ? "R8" : (!en_i ? "R7" : tag));
    end
  endtask

  task automatic mean_test(logic [20:0] f);
    longint sum, exp;
    sum = 0;
    frac_i = f; en_i = 1; clr_ni = 0;
    tick("R8");
    clr_ni = 1;
    for (int i = 0; i < 4096; i++) begin
      tick("R6");
      sum += longint'($signed(y_o));
    end
    exp = (longint'(f) * 4096) >>> 21;
    n_chk++;
    if (sum > exp + 4 || sum < exp - 4) begin
      n_bad++;
      $display("FAIL R1: actual %0d expected %0d (+-4)", sum, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_zero();
    #5;
    chk("R9", int'($signed(y_o)), 0);
    @(negedge clk_i);
    rst_ni = 1;

    // R10: zero fraction yields zero output
    frac_i = '0; en_i = 1;
    for (int i = 0; i < 50; i++) begin
      tick("R10");
      chk("R10", int'($signed(y_o)), 0);
    end

    // R2: near-full fraction, carries almost every edge
    frac_i = 21'h1F_FFFF;
    for (int i = 0; i < 200; i++) tick("R2");

    // R3/R4: mid fractions drive the tapered stages through wrap
    frac_i = 21'h0A_5A5A;
    for (int i = 0; i < 300; i++) tick("R3");
    frac_i = 21'h00_0333;
    for (int i = 0; i < 300; i++) tick("R4");

    // R7: hold then resume
    frac_i = 21'h13_579B;
    for (int i = 0; i < 20; i++) tick("R5");
    en_i = 0;
    for (int i = 0; i < 10; i++) tick("R7");
    en_i = 1;
    for (int i = 0; i < 40; i++) tick("R7");

    // R8: clear with enable high
    clr_ni = 0;
    tick("R8");
    clr_ni = 1;
    for (int i = 0; i < 30; i++) tick("R8");

    // random mixes
    for (int k = 0; k < 8; k++) begin
      frac_i = 21'($urandom);
      run("R5", 300, 80, 10);
    end

    // R1: mean tracks the fraction
    mean_test(21'd1);
    mean_test(21'h1F_FFFF);
    mean_test(21'h10_0000);
    mean_test(21'h03_3333);
    mean_test(21'($urandom));

    // R9: asynchronous reset mid-run
    frac_i = 21'h0F_0F0F;
    run("R6", 50, 100, 0);
    #1 rst_ni = 0;
    #1 chk("R9", int'($signed(y_o)), 0);
    m_zero();
    @(negedge clk_i);
    rst_ni = 1;
    run("R9", 50, 100, 0);

    summary();
  end
endmodule